// File: doc/BRIEF.md
# Timer Interrupt Router

This block sits between a bank of timer channels and the interrupt fabric. Each channel raises a one-cycle fire request when it expires. The router turns that request into one of three things: a held interrupt line (level delivery), a single-cycle pulse (edge delivery), or a 32-bit message write to a memory address (message delivery). Each channel's configuration selects the target line, the delivery type and whether the channel is enabled. A global enable covers every channel. Lines at or above a parameterised boundary (16 by default) are active-low, so the router drives them low to assert and high when idle.

A legacy replacement mode changes two lines. Channel 0 takes line 0 and channel 1 takes line 8, whatever their route fields say. The external periodic-timer and real-time-clock interrupt inputs, which otherwise pass through to lines 0 and 8, are shut off. A dedicated output tells the external periodic timer to stop while this mode is active. The real-time-clock level is recorded at all times, so line 8 can return to the correct level when the mode ends.

Each channel has its own state machine with three states. CH_QUIET means no line is driven. CH_HELD means a level interrupt is pending. CH_PULSE lasts for the one cycle of an edge pulse. The transitions are: QUIET or HELD or PULSE to HELD on a level fire; QUIET or HELD or PULSE to PULSE on an edge fire; PULSE to QUIET after one cycle; and any state to QUIET on a kill. A kill is a clear request, a channel disable, a global disable, or message mode being switched on. The legacy controller has two states, LG_NORMAL and LG_REPLACE. It moves between them whenever the legacy input differs from the current state. The message sender has two states. MS_IDLE picks the lowest-numbered pending channel and latches its address and data. MS_SEND presents the write and returns to MS_IDLE on the cycle the write is accepted.

Top module: `tir_router`

## Requirements
- R1: Outside legacy mode, a channel drives the line whose index equals its route field. A fire sampled at clock edge k changes that line at edge k+1, and the status bit at edge k.
- R2: While legacy mode is active, channel 0 drives line 0 and channel 1 drives line 8. Their route fields are ignored. Every other channel still uses its route field.
- R3: In level delivery (level bit 1), a fire sets the channel's status bit and holds its line asserted until a kill occurs.
- R4: In edge delivery (level bit 0), a fire asserts the line for exactly one cycle and leaves the status bit at 0.
- R5: Lines with index 16 or higher are active-low, and lines below 16 are active-high. During reset every line sits at its idle level, which is 32'hFFFF0000 with the default 32 lines.
- R6: A clear request, a channel disable or a global disable sets the status bit to 0 and deasserts the line. A clear wins over a fire in the same cycle.
- R7: In message mode, a fire drives no line and sets no status bit. It queues a write whose address is the channel's message-address field and whose data is its message-data field.
- R8: msg_valid stays high, with msg_addr and msg_data unchanged, until msg_ready is seen. When several channels are pending, the lowest-numbered channel is sent first.
- R9: Switching a channel's message mode from 0 to 1 sets its status bit to 0 and deasserts its line.
- R10: Entering legacy mode sets pit_enable to 0 one edge after legacy_en rises. From the following edge on, the external inputs no longer reach lines 0 and 8.
- R11: Leaving legacy mode sets pit_enable back to 1. Line 8 returns to the last real-time-clock level sampled, including levels sampled during legacy mode. Line 0 stays low until pit_in next changes.
- R12: Outside legacy mode, a change on pit_in appears on line 0, and rtc_in appears on line 8, two edges after the change.
- R13: After reset, pit_enable is 1, every status bit is 0, msg_valid is 0 and the recorded real-time-clock level is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fire | input | NCH | Per-channel expiry request, one cycle |
| clr | input | NCH | Per-channel clear request |
| ch_route | input | NCH*RW | Per-channel target line index |
| ch_level | input | NCH | 1 = level delivery, 0 = edge delivery |
| ch_en | input | NCH | Per-channel enable |
| ch_msg | input | NCH | Per-channel message delivery select |
| ch_msg_addr | input | NCH*32 | Per-channel message address |
| ch_msg_data | input | NCH*32 | Per-channel message data |
| glb_en | input | 1 | Global interrupt enable |
| legacy_en | input | 1 | Legacy replacement mode select |
| pit_in | input | 1 | External periodic-timer interrupt |
| rtc_in | input | 1 | External real-time-clock interrupt |
| msg_ready | input | 1 | Message write accepted |
| irq_line | output | NLINES | Interrupt lines, polarity per index |
| status | output | NCH | Level interrupt pending per channel |
| pit_enable | output | 1 | Periodic-timer enable, low in legacy mode |
| msg_valid | output | 1 | Message write request |
| msg_addr | output | 32 | Message write address |
| msg_data | output | 32 | Message write data |

## Verification
The bench targets several corner cases, each paired with the failure it would expose:
- Routing to line 15 and line 16 on either side of the polarity boundary. A polarity off by one would leave one of those lines at its idle level after a fire.
- A clear arriving in the same cycle as a fire. A design that let the fire win would leave the status bit set.
- Leaving legacy mode while pit_in is held high. A design that did not record the clock level, or that restored line 0 straight from pit_in, would show the wrong level on line 8 or a spurious high on line 0.
- Two message channels firing together while msg_ready is held low. A wrong priority, or a sender that moved on without acceptance, would show up as the wrong address or as msg_valid dropping early.

// File: rtl/tir_pkg.sv
package tir_pkg;
    localparam int LINE_PIT = 0;
    localparam int LINE_RTC = 8;

    typedef enum logic [1:0] {
        CH_QUIET = 2'd0,
        CH_HELD  = 2'd1,
        CH_PULSE = 2'd2
    } chan_state_t;

    typedef enum logic {
        LG_NORMAL  = 1'b0,
        LG_REPLACE = 1'b1
    } legacy_state_t;

    typedef enum logic {
        MS_IDLE = 1'b0,
        MS_SEND = 1'b1
    } msg_state_t;
endpackage

// File: rtl/tir_chan.sv
module tir_chan
    import tir_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    input  logic clr,
    input  logic level,
    input  logic en,
    input  logic msg_en,
    input  logic glb_en,
    output logic status,
    output logic drive,
    output logic msg_req,
    output logic drop
);
    chan_state_t state, state_nx;
    logic msg_q;
    logic kill;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= CH_QUIET;
            msg_q <= 1'b0;
        end else begin
            state <= state_nx;
            msg_q <= msg_en;
        end
    end

    assign drop = clr | ~en | ~glb_en;
    assign kill = drop | (msg_en & ~msg_q);

    always_comb begin
        state_nx = state;
        if (kill) begin
            state_nx = CH_QUIET;
        end else if (fire && !msg_en) begin
            state_nx = level ? CH_HELD : CH_PULSE;
        end else begin
            unique case (state)
                CH_QUIET: state_nx = CH_QUIET;
                CH_HELD:  state_nx = CH_HELD;
                CH_PULSE: state_nx = CH_QUIET;
                default:  state_nx = CH_QUIET;
            endcase
        end
    end

    assign status  = (state == CH_HELD);
    assign drive   = (state != CH_QUIET) & ~msg_en;
    assign msg_req = fire & msg_en & ~drop;

    // R4
    level_only_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status) |-> $past(level));
    // R6
    kill_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr || !en || !glb_en) |=> !status);
    // R9
    msg_on_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_en && !msg_q) |=> !status);
endmodule

// File: rtl/tir_legacy.sv
module tir_legacy
    import tir_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic legacy_en,
    input  logic pit_in,
    input  logic rtc_in,
    output logic legacy_on,
    output logic pit_enable,
    output logic ext_pit,
    output logic ext_rtc
);
    legacy_state_t state, state_nx;
    logic pit_q, pit_hold, rtc_lvl;

    always_comb begin
        state_nx = state;
        unique case (state)
            LG_NORMAL:  if (legacy_en)  state_nx = LG_REPLACE;
            LG_REPLACE: if (!legacy_en) state_nx = LG_NORMAL;
            default:    state_nx = LG_NORMAL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= LG_NORMAL;
        end else begin
            state <= state_nx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pit_enable <= 1'b1;
            pit_hold   <= 1'b0;
            pit_q      <= 1'b0;
            rtc_lvl    <= 1'b0;
        end else begin
            pit_q   <= pit_in;
            rtc_lvl <= rtc_in;
            if (state != state_nx) begin
                pit_enable <= (state_nx == LG_NORMAL);
                pit_hold   <= 1'b0;
            end else if (state == LG_NORMAL && pit_in != pit_q) begin
                pit_hold <= pit_in;
            end
        end
    end

    assign legacy_on = (state == LG_REPLACE);
    assign ext_pit   = (state == LG_NORMAL) & pit_hold;
    assign ext_rtc   = (state == LG_NORMAL) & rtc_lvl;

    // R10
    pit_off_in_legacy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pit_enable) |-> legacy_on);
    // R11
    pit_line_low_on_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pit_enable) |-> !ext_pit);
endmodule

// File: rtl/tir_msg.sv
module tir_msg
    import tir_pkg::*;
#(
    parameter int NCH = 4,
    parameter int AW  = 32,
    parameter int DW  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH-1:0]    req,
    input  logic [NCH-1:0]    drop,
    input  logic [NCH*AW-1:0] cfg_addr,
    input  logic [NCH*DW-1:0] cfg_data,
    input  logic              ready,
    output logic              valid,
    output logic [AW-1:0]     addr,
    output logic [DW-1:0]     data
);
    localparam int IW = (NCH > 1) ? $clog2(NCH) : 1;

    msg_state_t     state, state_nx;
    logic [NCH-1:0] pend, gmask;
    logic [IW-1:0]  idx;
    logic           found;

    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = 0; i < NCH; i++) begin
            if (pend[i] && !found) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end

    always_comb begin
        gmask    = '0;
        state_nx = state;
        unique case (state)
            MS_IDLE: if (found) begin
                state_nx   = MS_SEND;
                gmask[idx] = 1'b1;
            end
            MS_SEND: if (ready) state_nx = MS_IDLE;
            default: state_nx = MS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= MS_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend <= '0;
            addr <= '0;
            data <= '0;
        end else begin
            pend <= (pend & ~drop & ~gmask) | req;
            if (state == MS_IDLE && found) begin
                addr <= cfg_addr[idx*AW +: AW];
                data <= cfg_data[idx*DW +: DW];
            end
        end
    end

    assign valid = (state == MS_SEND);

    // R8
    msg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !ready) |=> (valid && $stable(addr) && $stable(data)));
    // R7
    msg_needs_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid) |-> $past(|pend));
endmodule

// File: rtl/tir_lines.sv
module tir_lines #(
    parameter int NCH    = 4,
    parameter int NLINES = 32,
    parameter int RW     = 5,
    parameter int ALOW   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH-1:0]    drive,
    input  logic [NCH*RW-1:0] route,
    input  logic              ext_pit,
    input  logic              ext_rtc,
    output logic [NLINES-1:0] irq_line
);
    logic [NLINES-1:0] active, pol;

    for (genvar l = 0; l < NLINES; l++) begin : g_line
        logic hit, ext_hit;
        always_comb begin
            hit = 1'b0;
            for (int c = 0; c < NCH; c++) begin
                if (drive[c] && route[c*RW +: RW] == RW'(l)) hit = 1'b1;
            end
        end
        if (l == tir_pkg::LINE_PIT) begin : g_pit
            assign ext_hit = ext_pit;
        end else if (l == tir_pkg::LINE_RTC) begin : g_rtc
            assign ext_hit = ext_rtc;
        end else begin : g_none
            assign ext_hit = 1'b0;
        end
        assign active[l] = hit | ext_hit;
        assign pol[l]    = (l >= ALOW);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_line <= pol;
        end else begin
            irq_line <= active ^ pol;
        end
    end
endmodule

// File: rtl/tir_router.sv
module tir_router
    import tir_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int NLINES = 32,
    parameter int ALOW   = 16,
    parameter int AW     = 32,
    parameter int DW     = 32,
    localparam int RW    = $clog2(NLINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH-1:0]    fire,
    input  logic [NCH-1:0]    clr,
    input  logic [NCH*RW-1:0] ch_route,
    input  logic [NCH-1:0]    ch_level,
    input  logic [NCH-1:0]    ch_en,
    input  logic [NCH-1:0]    ch_msg,
    input  logic [NCH*AW-1:0] ch_msg_addr,
    input  logic [NCH*DW-1:0] ch_msg_data,
    input  logic              glb_en,
    input  logic              legacy_en,
    input  logic              pit_in,
    input  logic              rtc_in,
    input  logic              msg_ready,
    output logic [NLINES-1:0] irq_line,
    output logic [NCH-1:0]    status,
    output logic              pit_enable,
    output logic              msg_valid,
    output logic [AW-1:0]     msg_addr,
    output logic [DW-1:0]     msg_data
);
    logic [NCH-1:0]    drive, msg_req, drop;
    logic [NCH*RW-1:0] eff_route;
    logic              legacy_on, ext_pit, ext_rtc;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        tir_chan u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .fire   (fire[c]),
            .clr    (clr[c]),
            .level  (ch_level[c]),
            .en     (ch_en[c]),
            .msg_en (ch_msg[c]),
            .glb_en (glb_en),
            .status (status[c]),
            .drive  (drive[c]),
            .msg_req(msg_req[c]),
            .drop   (drop[c])
        );
        if (c == 0) begin : g_leg0
            assign eff_route[c*RW +: RW] = legacy_on ? RW'(LINE_PIT) : ch_route[c*RW +: RW];
        end else if (c == 1) begin : g_leg1
            assign eff_route[c*RW +: RW] = legacy_on ? RW'(LINE_RTC) : ch_route[c*RW +: RW];
        end else begin : g_plain
            assign eff_route[c*RW +: RW] = ch_route[c*RW +: RW];
        end
    end

    tir_legacy u_legacy (
        .clk       (clk),
        .rst_n     (rst_n),
        .legacy_en (legacy_en),
        .pit_in    (pit_in),
        .rtc_in    (rtc_in),
        .legacy_on (legacy_on),
        .pit_enable(pit_enable),
        .ext_pit   (ext_pit),
        .ext_rtc   (ext_rtc)
    );

    tir_lines #(.NCH(NCH), .NLINES(NLINES), .RW(RW), .ALOW(ALOW)) u_lines (
        .clk     (clk),
        .rst_n   (rst_n),
        .drive   (drive),
        .route   (eff_route),
        .ext_pit (ext_pit),
        .ext_rtc (ext_rtc),
        .irq_line(irq_line)
    );

    tir_msg #(.NCH(NCH), .AW(AW), .DW(DW)) u_msg (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (msg_req),
        .drop    (drop),
        .cfg_addr(ch_msg_addr),
        .cfg_data(ch_msg_data),
        .ready   (msg_ready),
        .valid   (msg_valid),
        .addr    (msg_addr),
        .data    (msg_data)
    );

    // R2
    legacy_ch0_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (legacy_on && drive[0]) |=> (irq_line[LINE_PIT] == (LINE_PIT < ALOW)));
    // R13
    reset_pit_on_chk: assert property (@(posedge clk)
        !rst_n |=> pit_enable);
endmodule

// File: tb/sim_tir_router.sv
module sim_tir_router;
    localparam int NCH = 4;
    localparam int NL  = 32;
    localparam int RW  = 5;
    localparam logic [31:0] IDLE = 32'hFFFF0000;
    // {level, route}
    localparam logic [5:0] VEC [0:5] = '{6'b1_00011, 6'b1_10100, 6'b0_00101,
                                         6'b0_11111, 6'b1_10000, 6'b1_01111};

    logic clk = 1'b0, rst_n = 1'b0;
    logic [NCH-1:0] fire = '0, clr = '0, ch_level = '0, ch_en = '1, ch_msg = '0;
    logic [NCH*RW-1:0] ch_route = {5'd4, 5'd3, 5'd2, 5'd1};
    logic [NCH*32-1:0] ch_addr = {32'hA000_3000, 32'hA000_2000, 32'hA000_1000, 32'hA000_0000};
    logic [NCH*32-1:0] ch_data = {32'hD3, 32'hD2, 32'hD1, 32'hD0};
    logic glb_en = 1'b1, legacy_en = 1'b0, pit_in = 1'b0, rtc_in = 1'b0, msg_ready = 1'b0;
    logic [NL-1:0]  irq_line;
    logic [NCH-1:0] status;
    logic pit_enable, msg_valid;
    logic [31:0] msg_addr, msg_data;
    int checks = 0, fails = 0;

    always #10 clk = ~clk;

    tir_router u0 (
        .clk(clk), .rst_n(rst_n), .fire(fire), .clr(clr), .ch_route(ch_route),
        .ch_level(ch_level), .ch_en(ch_en), .ch_msg(ch_msg), .ch_msg_addr(ch_addr),
        .ch_msg_data(ch_data), .glb_en(glb_en), .legacy_en(legacy_en), .pit_in(pit_in),
        .rtc_in(rtc_in), .msg_ready(msg_ready), .irq_line(irq_line), .status(status),
        .pit_enable(pit_enable), .msg_valid(msg_valid), .msg_addr(msg_addr), .msg_data(msg_data)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        tick(); tick();
        // R5 R13 reset state
        chk("R5 reset lines", irq_line, IDLE);
        chk("R13 reset status", {28'd0, status}, 32'd0);
        chk("R13 reset pit_enable", {31'd0, pit_enable}, 32'd1);
        chk("R13 reset msg_valid", {31'd0, msg_valid}, 32'd0);
        rst_n = 1'b1;
        tick(); tick();
        chk("R13 rtc level zero", {31'd0, irq_line[8]}, 32'd0);

        // R1 R3 R4 R5 table walk on channel 2
        for (int i = 0; i < 6; i++) begin
            logic [4:0] rt;
            logic lv;
            logic [31:0] hit;
            rt  = VEC[i][4:0];
            lv  = VEC[i][5];
            hit = IDLE ^ (32'd1 << rt);
            ch_route[2*RW +: RW] = rt;
            ch_level[2] = lv;
            tick();
            fire[2] = 1'b1; tick(); fire[2] = 1'b0;
            chk(lv ? "R3 status set" : "R4 status clear", {31'd0, status[2]}, {31'd0, lv});
            tick();
            chk("R1 R5 line asserted", irq_line, hit);
            tick();
            chk(lv ? "R3 line held" : "R4 pulse ended", irq_line, lv ? hit : IDLE);
            clr[2] = 1'b1; tick(); clr[2] = 1'b0; tick();
            chk("R6 clear idles", irq_line, IDLE);
            chk("R6 clear status", {31'd0, status[2]}, 32'd0);
        end

        // R6 clear beats fire
        ch_route[2*RW +: RW] = 5'd3; ch_level[2] = 1'b1;
        fire[2] = 1'b1; clr[2] = 1'b1; tick(); fire[2] = 1'b0; clr[2] = 1'b0;
        chk("R6 clear wins status", {31'd0, status[2]}, 32'd0);
        tick();
        chk("R6 clear wins line", irq_line, IDLE);
        // R6 channel disable
        fire[2] = 1'b1; tick(); fire[2] = 1'b0; ch_en[2] = 1'b0; tick();
        chk("R6 disable status", {31'd0, status[2]}, 32'd0);
        tick();
        chk("R6 disable line", irq_line, IDLE);
        ch_en[2] = 1'b1;
        // R6 global disable
        fire[2] = 1'b1; tick(); fire[2] = 1'b0; glb_en = 1'b0; tick();
        chk("R6 global status", {31'd0, status[2]}, 32'd0);
        tick();
        chk("R6 global line", irq_line, IDLE);
        glb_en = 1'b1;

        // R9 message mode on kills held line
        fire[2] = 1'b1; tick(); fire[2] = 1'b0; tick();
        chk("R9 held before", irq_line, IDLE ^ 32'h8);
        ch_msg[2] = 1'b1; tick();
        chk("R9 status cleared", {31'd0, status[2]}, 32'd0);
        tick();
        chk("R9 line cleared", irq_line, IDLE);
        chk("R9 no message", {31'd0, msg_valid}, 32'd0);
        ch_msg[2] = 1'b0;

        // R7 R8 messages on channels 1 and 3
        ch_msg[1] = 1'b1; ch_msg[3] = 1'b1; ch_level[3] = 1'b1;
        tick();
        fire[1] = 1'b1; fire[3] = 1'b1; tick(); fire = '0; tick();
        chk("R8 valid", {31'd0, msg_valid}, 32'd1);
        chk("R8 lowest first addr", msg_addr, 32'hA000_1000);
        chk("R7 data", msg_data, 32'hD1);
        tick(); tick(); tick();
        chk("R8 held valid", {31'd0, msg_valid}, 32'd1);
        chk("R8 held addr", msg_addr, 32'hA000_1000);
        chk("R7 no line", irq_line, IDLE);
        chk("R7 no status", {28'd0, status}, 32'd0);
        msg_ready = 1'b1; tick(); msg_ready = 1'b0;
        chk("R8 drop after accept", {31'd0, msg_valid}, 32'd0);
        tick();
        chk("R8 second valid", {31'd0, msg_valid}, 32'd1);
        chk("R8 second addr", msg_addr, 32'hA000_3000);
        chk("R7 second data", msg_data, 32'hD3);
        msg_ready = 1'b1; tick(); msg_ready = 1'b0;
        chk("R8 queue empty", {31'd0, msg_valid}, 32'd0);
        ch_msg = '0;

        // R12 pass-through
        pit_in = 1'b1; rtc_in = 1'b1; tick(); tick();
        chk("R12 pit on line0", {31'd0, irq_line[0]}, 32'd1);
        chk("R12 rtc on line8", {31'd0, irq_line[8]}, 32'd1);

        // R10 enter legacy
        legacy_en = 1'b1; tick();
        chk("R10 pit_enable low", {31'd0, pit_enable}, 32'd0);
        tick();
        chk("R10 lines 0 8 idle", irq_line, IDLE);

        // R2 legacy routing
        ch_level[0] = 1'b1; fire[0] = 1'b1; tick(); fire[0] = 1'b0; tick();
        chk("R2 ch0 on line0", irq_line, IDLE ^ 32'h1);
        clr[0] = 1'b1; tick(); clr[0] = 1'b0; tick();
        ch_level[1] = 1'b0; fire[1] = 1'b1; tick(); fire[1] = 1'b0; tick();
        chk("R2 ch1 pulse on line8", irq_line, IDLE ^ 32'h100);
        tick();
        fire[2] = 1'b1; ch_level[2] = 1'b1; tick(); fire[2] = 1'b0; tick();
        chk("R2 ch2 keeps route", irq_line, IDLE ^ 32'h8);
        clr[2] = 1'b1; tick(); clr[2] = 1'b0;
        rtc_in = 1'b0; tick(); tick();
        chk("R10 rtc gated", {31'd0, irq_line[8]}, 32'd0);
        rtc_in = 1'b1; tick();

        // R11 leave legacy
        legacy_en = 1'b0; tick();
        chk("R11 pit_enable high", {31'd0, pit_enable}, 32'd1);
        tick();
        chk("R11 line8 restored", {31'd0, irq_line[8]}, 32'd1);
        chk("R11 line0 low", {31'd0, irq_line[0]}, 32'd0);
        pit_in = 1'b0; tick(); tick();
        pit_in = 1'b1; tick(); tick();
        chk("R12 pit toggles back", {31'd0, irq_line[0]}, 32'd1);

        finish_run();
    end
endmodule